// File: doc/BRIEF.md
# I2C Register-Access Target

This block is an I2C target that gives an external bus master access to a bank of 8-bit internal registers. It samples SCL and SDA on the system clock through two-flop synchronisers and recognises START, repeated START and STOP from those samples. It compares the first byte of each transfer against a 7-bit device address set by a parameter. It acknowledges the bytes it accepts, and it returns read data by pulling SDA low through an open-drain enable.

Register access uses an 8-bit pointer that the block keeps between transfers. A write transfer loads the pointer from the byte that follows the select code. Each later data byte is written at the pointer, and the pointer then steps on. A read transfer sends bytes from the pointer, so the master can read at the current address by sending only a select code. To read at a chosen address, the master sends a short write that sets the pointer, then a repeated START and a read select code. The register file sits behind a simple synchronous port. Its read data must follow the presented address within one clock.

Top module: `i2c_reg_target`

## Requirements
- R1: A select code is a byte, MSB first, made of the 7-bit device address followed by a direction bit (0 = write, 1 = read). When the address matches, the target acknowledges the byte by holding SDA low during the ninth SCL pulse.
- R2: A select code with a non-matching address gets no acknowledge. The target then leaves SDA released and writes nothing until the next START, even while further bytes are clocked.
- R3: In a write transfer, the byte after the select code is acknowledged and replaces the pointer.
- R4: Each later byte of a write transfer is acknowledged and stored at the pointer with a single one-cycle write strobe. The pointer then steps by one, so a burst fills consecutive addresses.
- R5: The pointer is 8 bits wide and steps from 0xFF to 0x00.
- R6: The pointer keeps its value across STOP. A read select code with no address phase returns data starting at the pointer.
- R7: A write select code, an address byte, a repeated START and then a read select code return data starting at that address.
- R8: Read data is sent MSB first. After each byte sent, the pointer steps by one. A master ACK (SDA low on the ninth pulse) causes the byte at the new pointer to be sent.
- R9: After a master NACK on a read byte, the target keeps SDA released on every following SCL pulse until START or STOP.
- R10: The SDA output enable changes only while SCL is low.
- R11: A START or STOP in the middle of a byte abandons that byte without a register write. A START begins a new select-code phase.
- R12: While reset is asserted, SDA is released, the write strobe is low and the pointer is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that samples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| reg_addr_o | output | 8 | Register address (current pointer) |
| reg_wdata_o | output | 8 | Register write data |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_rdata_i | input | 8 | Register read data for reg_addr_o, valid one clock after the address |

## Verification
A bus condition can arrive while a byte is still being shifted in. A STOP or repeated START then competes with the byte assembly that would otherwise complete and fire the write strobe. The bench provokes this by clocking only three or four bits of a data byte before issuing STOP, and in a second case a repeated START. It judges the result by counting write strobes at the register port and by reading back the target addresses through the bus. It also confirms that the repeated START taken mid-byte is accepted as a fresh select code, and that this select code reads from the pointer the aborted write had just loaded.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_WAIT
  } tgt_state_e;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_d  <= scl_ff[SYNC_STAGES-1];
      sda_d  <= sda_ff[SYNC_STAGES-1];
    end
  end

  assign scl_o      = scl_ff[SYNC_STAGES-1];
  assign sda_o      = sda_ff[SYNC_STAGES-1];
  assign scl_rise_o = !scl_d && scl_o;
  assign scl_fall_o = scl_d && !scl_o;
  // bus conditions: SDA edge while SCL held high
  assign start_o    = scl_d && scl_o && sda_d && !sda_o;
  assign stop_o     = scl_d && scl_o && !sda_d && sda_o;
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter logic [BYTE_W-2:0] DEV_ADDR = 7'h2A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] ptr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              we_o,
  input  logic [BYTE_W-1:0] rdata_i
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  tgt_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg, txsh, ptr, rx_byte;
  logic              sda_oe, we, rw, mack;

  assign rx_byte = {shreg[BYTE_W-2:0], sda_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      shreg   <= '0;
      txsh    <= '0;
      ptr     <= '0;
      wdata_o <= '0;
      sda_oe  <= 1'b0;
      we      <= 1'b0;
      rw      <= 1'b0;
      mack    <= 1'b0;
    end else begin
      we <= 1'b0;
      if (we) ptr <= ptr + 1'b1;
      if (stop_i) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_i) begin
        state  <= ST_DEV;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_DEV, ST_ADDR, ST_WR: begin
            if (scl_rise_i) begin
              shreg <= rx_byte;
              cnt   <= cnt + 1'b1;
              if (cnt == LAST) begin
                cnt <= '0;
                if (state == ST_DEV) begin
                  if (rx_byte[BYTE_W-1:1] == DEV_ADDR) begin
                    rw    <= rx_byte[0];
                    state <= ST_DEV_ACK;
                  end else begin
                    state <= ST_WAIT;
                  end
                end else if (state == ST_ADDR) begin
                  ptr   <= rx_byte;
                  state <= ST_ADDR_ACK;
                end else begin
                  wdata_o <= rx_byte;
                  we      <= 1'b1;
                  state   <= ST_WR_ACK;
                end
              end
            end
          end
          ST_DEV_ACK, ST_ADDR_ACK, ST_WR_ACK: begin
            // first fall opens the ack slot, second fall closes it
            if (scl_fall_i) begin
              if (!sda_oe) begin
                sda_oe <= 1'b1;
              end else begin
                sda_oe <= 1'b0;
                if (state == ST_DEV_ACK && rw) begin
                  txsh   <= rdata_i;
                  sda_oe <= !rdata_i[BYTE_W-1];
                  cnt    <= '0;
                  state  <= ST_RD;
                end else if (state == ST_DEV_ACK) begin
                  state <= ST_ADDR;
                end else begin
                  state <= ST_WR;
                end
              end
            end
          end
          ST_RD: begin
            if (scl_fall_i) begin
              if (cnt == LAST) begin
                sda_oe <= 1'b0;
                ptr    <= ptr + 1'b1;
                cnt    <= '0;
                state  <= ST_RD_ACK;
              end else begin
                txsh   <= txsh << 1;
                sda_oe <= !txsh[BYTE_W-2];
                cnt    <= cnt + 1'b1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise_i) mack <= !sda_i;
            if (scl_fall_i) begin
              if (mack) begin
                txsh   <= rdata_i;
                sda_oe <= !rdata_i[BYTE_W-1];
                cnt    <= '0;
                state  <= ST_RD;
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = sda_oe;
  assign ptr_o    = ptr;
  assign we_o     = we;

  a_r10_oe_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe) |-> !$past(scl_i));
  a_r4_we_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we |=> !we);
  a_r5_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we |=> (ptr == $past(ptr) + 8'd1));
  a_r2_wait_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_WAIT) |-> (!sda_oe && !we));
  a_r9_nack_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_RD_ACK && scl_fall_i && !mack && !start_i && !stop_i)
      |=> (state == ST_WAIT && !sda_oe));
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [BYTE_W-2:0] DEV_ADDR    = 7'h2A,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);
  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;

  i2c_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (bus_start),
    .stop_o     (bus_stop)
  );

  i2c_tgt_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_s),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (bus_start),
    .stop_i     (bus_stop),
    .sda_oe_o   (sda_oe_o),
    .ptr_o      (reg_addr_o),
    .wdata_o    (reg_wdata_o),
    .we_o       (reg_we_o),
    .rdata_i    (reg_rdata_i)
  );
endmodule

// File: tb/sim_i2c_reg_target.sv
`timescale 1ns/1ps
module sim_i2c_reg_target;
  localparam int Q = 8;
  localparam logic [7:0] SEL_W = 8'h54;
  localparam logic [7:0] SEL_R = 8'h55;
  localparam int NV = 6;
  // {register address, data}
  localparam logic [15:0] VEC [NV] = '{16'h003C, 16'h01C3, 16'h7F00,
                                       16'h80FF, 16'hFE5A, 16'hFFA5};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, we;
  logic [7:0] raddr, wdata, rdata;
  wire sda_line = sda_m & ~sda_oe;

  logic [7:0] mem [256];
  logic [7:0] expm [256];
  int nchk = 0, nfail = 0, we_cnt = 0, oe_viol = 0;
  logic oe_prev = 1'b0;

  i2c_reg_target #(.DEV_ADDR(7'h2A)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .reg_addr_o(raddr), .reg_wdata_o(wdata),
    .reg_we_o(we), .reg_rdata_i(rdata)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'hA5;
    end else if (we) begin
      mem[raddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

  always @(posedge clk) begin
    if (we) we_cnt <= we_cnt + 1;
    if (rst_n && sda_oe !== oe_prev && scl) oe_viol <= oe_viol + 1;
    oe_prev <= sda_oe;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tk(Q); scl = 1'b1; tk(Q); sda_m = 1'b0; tk(Q); scl = 1'b0; tk(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tk(Q); scl = 1'b1; tk(Q); sda_m = 1'b1; tk(Q);
  endtask

  task automatic bit_out(logic b);
    sda_m = b; tk(Q); scl = 1'b1; tk(Q); scl = 1'b0; tk(Q);
  endtask

  task automatic wbyte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    sda_m = 1'b1; tk(Q); scl = 1'b1; tk(Q/2);
    ack = ~sda_line;
    tk(Q/2); scl = 1'b0; tk(Q);
  endtask

  task automatic rbyte(logic mack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tk(Q); scl = 1'b1; tk(Q/2);
      d[i] = sda_line;
      tk(Q/2); scl = 1'b0;
    end
    sda_m = ~mack; tk(Q); scl = 1'b1; tk(Q); scl = 1'b0; tk(2);
    sda_m = 1'b1; tk(Q);
  endtask

  task automatic set_ptr(logic [7:0] a);
    logic ack;
    bus_start();
    wbyte(SEL_W, ack); chk("R1 select ack", ack, 1);
    wbyte(a, ack);     chk("R3 address ack", ack, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    int w0;
    for (int i = 0; i < 256; i++) expm[i] = 8'(i) ^ 8'hA5;
    tk(5);
    chk("R12 reset sda", sda_oe, 0);
    chk("R12 reset we", we, 0);
    chk("R12 reset ptr", raddr, 0);
    rst_n = 1'b1; tk(5);

    // vector table: single write then random read
    for (int v = 0; v < NV; v++) begin
      set_ptr(VEC[v][15:8]);
      wbyte(VEC[v][7:0], ack); chk("R4 data ack", ack, 1);
      bus_stop();
      expm[VEC[v][15:8]] = VEC[v][7:0];
      set_ptr(VEC[v][15:8]);
      bus_start();
      wbyte(SEL_R, ack); chk("R7 read select ack", ack, 1);
      rbyte(1'b0, d);    chk("R7 random read", d, expm[VEC[v][15:8]]);
      bus_stop();
    end

    // burst write 0x10..0x13
    w0 = we_cnt;
    set_ptr(8'h10);
    for (int i = 0; i < 4; i++) begin
      wbyte(8'h11 * 8'(i + 1), ack); chk("R4 burst ack", ack, 1);
      expm[8'h10 + 8'(i)] = 8'h11 * 8'(i + 1);
    end
    bus_stop();
    chk("R4 strobe count", we_cnt - w0, 4);

    // random burst read: ack, ack, nack
    set_ptr(8'h10);
    bus_start();
    wbyte(SEL_R, ack);
    rbyte(1'b1, d); chk("R8 burst byte0", d, expm[8'h10]);
    rbyte(1'b1, d); chk("R8 burst byte1", d, expm[8'h11]);
    rbyte(1'b0, d); chk("R8 burst byte2", d, expm[8'h12]);
    rbyte(1'b0, d); chk("R9 released after nack", d, 8'hFF);
    bus_stop();

    // current-address reads, pointer kept across STOP
    bus_start(); wbyte(SEL_R, ack); chk("R6 select ack", ack, 1);
    rbyte(1'b0, d); chk("R6 current read", d, expm[8'h13]);
    bus_stop();
    bus_start(); wbyte(SEL_R, ack);
    rbyte(1'b0, d); chk("R6 current read next", d, expm[8'h14]);
    bus_stop();

    // pointer wrap
    set_ptr(8'hFF);
    wbyte(8'hE1, ack); wbyte(8'hE2, ack);
    bus_stop();
    expm[8'hFF] = 8'hE1; expm[8'h00] = 8'hE2;
    bus_start(); wbyte(SEL_R, ack);
    rbyte(1'b0, d); chk("R5 pointer after wrap", d, expm[8'h01]);
    bus_stop();
    set_ptr(8'hFF); bus_start(); wbyte(SEL_R, ack);
    rbyte(1'b1, d); chk("R5 read at 0xFF", d, 8'hE1);
    rbyte(1'b0, d); chk("R5 read at 0x00", d, 8'hE2);
    bus_stop();

    // mismatching select code
    w0 = we_cnt;
    bus_start();
    wbyte(8'hA0, ack); chk("R2 no select ack", ack, 0);
    wbyte(8'h20, ack); chk("R2 no addr ack", ack, 0);
    wbyte(8'h77, ack); chk("R2 no data ack", ack, 0);
    bus_stop();
    chk("R2 no strobe", we_cnt - w0, 0);
    set_ptr(8'h20); bus_start(); wbyte(SEL_R, ack);
    rbyte(1'b0, d); chk("R2 register untouched", d, expm[8'h20]);
    bus_stop();

    // mid-byte STOP and repeated START
    w0 = we_cnt;
    set_ptr(8'h30);
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
    bus_stop();
    set_ptr(8'h31);
    bit_out(1'b0); bit_out(1'b1); bit_out(1'b1);
    bus_start();
    wbyte(SEL_R, ack); chk("R11 select after mid-byte start", ack, 1);
    rbyte(1'b0, d);    chk("R11 read from loaded pointer", d, expm[8'h31]);
    bus_stop();
    chk("R11 no partial write", we_cnt - w0, 0);
    set_ptr(8'h30); bus_start(); wbyte(SEL_R, ack);
    rbyte(1'b0, d); chk("R11 register 0x30 intact", d, expm[8'h30]);
    bus_stop();

    chk("R10 sda changes with scl high", oe_viol, 0);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule